// File: doc/BRIEF.md
# Replicated Round-Robin Bus Arbiter

This block decides which agent may drive a shared address bus. One copy sits beside every agent. Every copy sees the same five request lines: four ordinary masters and one system controller. Every copy runs the same logic from reset, so all copies compute the same grant on every cycle. No central arbiter is needed. Each grant covers one request packet, which holds the bus for a fixed number of cycles (two by default). The grant never moves while a packet is in flight.

The controller outranks all masters. Among the masters the choice is round-robin, with a short preference for the master that owned the bus last. That master gets one extra back-to-back packet, which cuts latency for bursts from the same agent. When parking is enabled and nobody requests, the grant stays on the last master owner. That master can then start its next packet in the same cycle it raises its request, with no arbitration delay.

Each copy drives the full one-hot grant vector and a local ownership flag for the master index it was built for.

Top module: `bus_share_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the grant vector is all zeros and the ownership flag is low.
- R2: At most one grant bit is high in any cycle. The ownership flag equals the grant bit at index MY_INDEX. Bits 0 to 3 are masters 0 to 3, and bit 4 is the system controller.
- R3: At a decision point, a controller request (bit 4) wins over every master request. The one exception is the parked-owner case of R9.
- R4: A granted packet holds the same grant for exactly PKT_CYCLES consecutive cycles. The grant does not change before the last cycle of the packet has passed.
- R5: Decision points are every cycle with no packet in flight, plus the last cycle of each packet. Requests sampled at a decision point produce the new grant in the next cycle.
- R6: Without hysteresis, the masters are searched in ascending index order. The search starts at the master after the last master owner and wraps from 3 to 0. Before any master has owned the bus, it starts at 0.
- R7: Hysteresis: if the last master owner requests at a decision point, and its most recent packet was not already a repeat, it wins again (when the controller is idle). A repeat is a packet won by the master that was already the last master owner. After a repeat, the search of R6 applies.
- R8: If no line requests at a decision point, the next grant depends on parking. With parking enabled, the grant goes to the last master owner. With parking disabled, or before any master has owned the bus, the grant is zero. The controller is never parked.
- R9: A parked master that raises its request owns a packet that starts in that same cycle. The grant stays unchanged for PKT_CYCLES cycles counting that cycle, even if the controller requests at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_MASTERS+1 | Request lines; top bit is the system controller |
| park_en_i | input | 1 | Enables parking on the last master owner |
| grant_o | output | NUM_MASTERS+1 | One-hot bus grant, zero when unowned |
| own_o | output | 1 | High when this copy's master (MY_INDEX) holds the grant |

## Verification
Some properties are checked by the assertions on every cycle. These are the one-hot grant, the frozen grant inside a packet, the controller's win at a decision point, that a new owner is always one that requested, the release of the bus when parking is off, and that a parked owner's immediate start holds the grant. Other properties can only be shown by the bench's directed scenarios, because they depend on history. These are the exact round-robin order and its wrap, the single extra packet allowed by hysteresis, where parking lands after a controller packet, and the same-cycle start of a parked owner ahead of a simultaneous controller request.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;
  // Reason a grant was chosen at a decision point.
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_CTRL = 2'd1,
    PICK_HOLD = 2'd2,
    PICK_RR   = 2'd3
  } pick_src_e;
endpackage

// File: rtl/rrarb_rr_pick.sv
module rrarb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  localparam logic [IW:0] NV = N[IW:0];

  logic [IW:0] pos;

  // Walk from the highest offset down so the smallest offset from start wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    pos   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      pos = {1'b0, start} + k[IW:0];
      if (pos >= NV) pos = pos - NV;
      if (req[pos[IW-1:0]]) begin
        found = 1'b1;
        idx   = pos[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/rrarb_pkt_timer.sv
module rrarb_pkt_timer #(
  parameter int PKT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,      // packet begins next cycle
  input  logic launch_now,  // packet began this cycle
  output logic pkt_active,
  output logic pkt_last
);
  localparam int CW = (PKT_CYCLES > 1) ? $clog2(PKT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PKT_CYCLES - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (launch) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (launch_now) begin
      active_d = 1'b1;
      cnt_d    = ONE;
    end else if (active_q && (cnt_q == LAST)) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active_q) begin
      cnt_d    = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign pkt_active = active_q;
  assign pkt_last   = active_q && (cnt_q == LAST);
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
  import rrarb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int PKT_CYCLES  = 2,
  parameter int MY_INDEX    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS:0]   req_i,
  input  logic                   park_en_i,
  output logic [NUM_MASTERS:0]   grant_o,
  output logic                   own_o
);
  localparam int IW   = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam int CTRL = NUM_MASTERS;
  localparam logic [IW-1:0] LAST_M = IW'(NUM_MASTERS - 1);

  logic [NUM_MASTERS:0] grant_q, grant_d;
  logic [IW-1:0]        last_q, last_d;
  logic                 last_vld_q, last_vld_d;
  logic                 repeat_q, repeat_d;
  logic                 state_en;

  logic                 pkt_active, pkt_last;
  logic                 parked, park_start, decide, launch;
  logic                 hold_ok, rr_found;
  logic [IW-1:0]        rr_start, rr_idx;
  logic [NUM_MASTERS:0] last_oh, rr_oh;
  pick_src_e            pick;

  // One-hot decodes of the master indices.
  generate
    for (genvar g = 0; g <= NUM_MASTERS; g++) begin : g_oh
      if (g < NUM_MASTERS) begin : g_m
        assign last_oh[g] = (last_q == IW'(g));
        assign rr_oh[g]   = (rr_idx == IW'(g));
      end else begin : g_c
        assign last_oh[g] = 1'b0;
        assign rr_oh[g]   = 1'b0;
      end
    end
  endgenerate

  assign parked     = !pkt_active && (grant_q[NUM_MASTERS-1:0] != '0);
  assign park_start = parked && ((req_i[NUM_MASTERS-1:0] & grant_q[NUM_MASTERS-1:0]) != '0);
  assign decide     = !park_start && (!pkt_active || pkt_last);
  assign hold_ok    = last_vld_q && req_i[last_q] && !repeat_q;
  assign rr_start   = !last_vld_q ? '0 : ((last_q == LAST_M) ? '0 : last_q + IW'(1));

  rrarb_rr_pick #(.N(NUM_MASTERS), .IW(IW)) u_pick (
    .req   (req_i[NUM_MASTERS-1:0]),
    .start (rr_start),
    .found (rr_found),
    .idx   (rr_idx)
  );

  always_comb begin
    if (req_i[CTRL])  pick = PICK_CTRL;
    else if (hold_ok) pick = PICK_HOLD;
    else if (rr_found) pick = PICK_RR;
    else              pick = PICK_NONE;
  end

  // Next-state computation.
  always_comb begin
    grant_d    = grant_q;
    last_d     = last_q;
    last_vld_d = last_vld_q;
    repeat_d   = repeat_q;
    launch     = 1'b0;
    state_en   = decide || park_start;
    if (park_start) begin
      repeat_d = 1'b1;
    end else if (decide) begin
      unique case (pick)
        PICK_CTRL: begin
          grant_d       = '0;
          grant_d[CTRL] = 1'b1;
          launch        = 1'b1;
        end
        PICK_HOLD: begin
          grant_d  = last_oh;
          repeat_d = 1'b1;
          launch   = 1'b1;
        end
        PICK_RR: begin
          grant_d    = rr_oh;
          last_d     = rr_idx;
          last_vld_d = 1'b1;
          repeat_d   = last_vld_q && (rr_idx == last_q);
          launch     = 1'b1;
        end
        default: begin
          grant_d = (park_en_i && last_vld_q) ? last_oh : '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q    <= '0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
      repeat_q   <= 1'b0;
    end else if (state_en) begin
      grant_q    <= grant_d;
      last_q     <= last_d;
      last_vld_q <= last_vld_d;
      repeat_q   <= repeat_d;
    end
  end

  rrarb_pkt_timer #(.PKT_CYCLES(PKT_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .launch_now (park_start),
    .pkt_active (pkt_active),
    .pkt_last   (pkt_last)
  );

  assign grant_o = grant_q;
  assign own_o   = grant_q[MY_INDEX];
endmodule

// File: rtl/rrarb_chk.sv
module rrarb_chk #(
  parameter int NUM_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_MASTERS:0] req_i,
  input logic                 park_en_i,
  input logic [NUM_MASTERS:0] grant_o,
  input logic                 pkt_active,
  input logic                 pkt_last,
  input logic                 decide,
  input logic                 park_start
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R2
  AST_MIDPKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_active && !pkt_last) |=> $stable(grant_o)); // R4
  AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req_i[NUM_MASTERS]) |=> grant_o[NUM_MASTERS]); // R3
  AST_NEW_OWNER_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req_i != '0) |=> ((grant_o & $past(req_i)) != '0)); // R5
  AST_UNPARKED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && req_i == '0 && !park_en_i) |=> (grant_o == '0)); // R8
  AST_CTRL_NOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[NUM_MASTERS] |-> pkt_active); // R8
  AST_PARK_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    park_start |=> ($stable(grant_o) && pkt_active)); // R9
endmodule

bind bus_share_arbiter rrarb_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .park_en_i  (park_en_i),
  .grant_o    (grant_o),
  .pkt_active (pkt_active),
  .pkt_last   (pkt_last),
  .decide     (decide),
  .park_start (park_start)
);

// File: tb/bus_share_arbiter_test.sv
`timescale 1ns/1ps
module bus_share_arbiter_test;
  localparam int NM = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM:0]   req = '0;
  logic          park_en = 1'b0;
  logic [NM:0]   grant;
  logic          own;
  int            n_run = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  bus_share_arbiter #(.NUM_MASTERS(NM), .PKT_CYCLES(2), .MY_INDEX(1)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .park_en_i(park_en),
    .grant_o(grant), .own_o(own)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [NM:0] exp_g);
    n_run++;
    if (grant !== exp_g || own !== exp_g[1]) begin
      n_fail++;
      $display("FAIL %s: grant=%b own=%b expected grant=%b own=%b",
               tag, grant, own, exp_g, exp_g[1]);
    end
  endtask

  task automatic t_reset();
    #1; chk("R1 in reset", 5'b00000);
    tick(); tick();
    rst_n = 1'b1;
    tick(); chk("R1 after release", 5'b00000);
  endtask

  task automatic t_single();
    req = 5'b00100;
    tick(); chk("R5 m2 granted", 5'b00100);
    req = 5'b00000;
    tick(); chk("R4 m2 second cycle", 5'b00100);
    tick(); chk("R8 no park releases", 5'b00000);
  endtask

  task automatic t_ctrl_rr();
    req = 5'b10011;
    tick(); chk("R3 controller wins", 5'b10000);
    req = 5'b00011;
    tick(); chk("R4 controller holds", 5'b10000);
    tick(); chk("R6 wrap 3->0 picks m0", 5'b00001);
    req = 5'b00010;
    tick(); chk("R4 m0 holds", 5'b00001);
    tick(); chk("R6 m1 next, R2 own", 5'b00010);
    req = 5'b00000;
    tick(); tick(); chk("R8 idle zero", 5'b00000);
  endtask

  task automatic t_hyst();
    req = 5'b00110;
    tick(); chk("R7 last owner m1 kept", 5'b00010);
    tick();
    tick(); chk("R7 repeat used, R6 m2", 5'b00100);
    tick();
    tick(); chk("R7 m2 kept once", 5'b00100);
    tick();
    tick(); chk("R6 m1 after m2 repeat", 5'b00010);
    req = 5'b00000;
    tick();
    tick(); chk("R8 release after hyst", 5'b00000);
  endtask

  task automatic t_park();
    park_en = 1'b1;
    tick(); chk("R8 park on m1", 5'b00010);
    tick(); chk("R8 park stays", 5'b00010);
    req = 5'b00010;
    #0.5; chk("R9 grant already present", 5'b00010);
    tick(); chk("R9 packet cycle two", 5'b00010);
    req = 5'b00000;
    tick(); chk("R8 back to park", 5'b00010);
    req = 5'b01000;
    tick(); chk("R6 m3 takes parked bus", 5'b01000);
    req = 5'b00000;
    tick(); tick(); chk("R8 park on m3", 5'b01000);
    req = 5'b10000;
    tick(); chk("R3 controller from park", 5'b10000);
    req = 5'b00000;
    tick(); tick(); chk("R8 park returns to m3", 5'b01000);
    req = 5'b11000;
    tick(); chk("R9 parked m3 beats ctrl", 5'b01000);
    req = 5'b10000;
    tick(); chk("R3 ctrl after parked packet", 5'b10000);
    req = 5'b00000;
    park_en = 1'b0;
    tick(); tick(); chk("R8 park off releases", 5'b00000);
  endtask

  task automatic t_midpkt();
    req = 5'b00001;
    tick(); chk("R6 m0 from idle", 5'b00001);
    req = 5'b10000;
    tick(); chk("R4 no preempt mid packet", 5'b00001);
    tick(); chk("R3 ctrl at boundary", 5'b10000);
    req = 5'b00000;
    tick(); tick(); chk("R8 idle again", 5'b00000);
  endtask

  task automatic t_async_reset();
    req = 5'b00100;
    tick(); chk("R5 m2 before reset", 5'b00100);
    rst_n = 1'b0;
    req = 5'b00000;
    #0.5; chk("R1 async clear", 5'b00000);
    tick();
    rst_n = 1'b1;
    tick(); chk("R1 stays clear", 5'b00000);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_ctrl_rr();
    t_hyst();
    t_park();
    t_midpkt();
    t_async_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule